// File: doc/BRIEF.md
# Processor Interrupt Controller

This block collects up to 32 interrupt request lines next to a processor core and presents them to software through two registers: an enable mask and a pending status word. It latches requests into the status word and raises a single request towards the core whenever a pending line is also enabled. A small register port lets software read either register and write either one. Software typically changes the mask by reading it, altering one bit and writing it back.

A build-time parameter picks how the status word behaves. In level mode it simply samples the inputs. In edge mode a rising input sets a bit, and software clears it by writing a one. In latched-level mode a high input sets a bit that stays set after the input falls, and software clears it by writing a zero. That last mode lets a read-modify-write which clears one bit leave every other bit alone. A combinational pick output reports the lowest-numbered line that is both pending and enabled, because handlers service lines in ascending order.

Top module: `cpu_irq_ctrl`

## Requirements
- R1: Each of the 32 lines owns one bit of the mask and one bit of the status word, at the bit position equal to its line number. With `reg_sel` = 0, `reg_rdata` shows the mask and a write with `reg_wr` high loads `reg_wdata` into the mask at the next clock edge. With `reg_sel` = 1, `reg_rdata` shows the status word in the same cycle and a write goes to the status word.
- R2: While `rst_n` is low at a clock edge, the mask, the status word, `cpu_irq` and the pick output are cleared, so every line starts disabled.
- R3: In edge mode (MODE = ACK_EDGE_W1C), an input that was low at one clock edge and is high at the next sets its status bit at that next edge. Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R4: In edge mode, when a rising edge and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R5: In latched-level mode (MODE = ACK_LATCH_W0C, the default), an input that is high at a clock edge sets its status bit. The bit stays set after the input falls, until software clears it.
- R6: In latched-level mode, writing 0 to a status bit clears it and writing 1 leaves it unchanged. An input that is still high in the cycle of the clearing write keeps its bit set.
- R7: In level mode (MODE = ACK_LEVEL), the status word equals the inputs sampled at the previous clock edge, and writes to the status word have no effect.
- R8: `cpu_irq` is the OR of (status AND mask) as it stood one clock edge earlier. It is therefore low in the first cycle after an enabling mask write and high from the cycle after that.
- R9: `pend_valid` is high exactly when (status AND mask) is non-zero. `pend_idx` then gives the lowest set bit position. When nothing is pending, `pend_idx` is 0.
- R10: A status bit is set and held regardless of its mask bit, so a masked line still reads as pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 32 | Interrupt request lines, one per bit |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 mask, 1 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register contents |
| cpu_irq | output | 1 | Registered interrupt request to the core |
| pend_valid | output | 1 | Some enabled line is pending |
| pend_idx | output | 5 | Lowest enabled pending line |

## Verification
The assertions take for granted that `irq_in` and the register port are sampled synchronously to `clk` and are already free of glitches. They also assume that reset is held low from time zero until at least one clock edge has passed. The bench drives every input a fixed delay after the rising edge and keeps `rst_n` low from the start. The write-data and set/clear checks compare against the previous cycle's sampled inputs only, so the stimulus never changes an input twice between edges.

// File: rtl/cpu_irq_pkg.sv
// Package: shared types for the interrupt controller.
// Holds the acknowledge-mode selector and the register select codes.
package cpu_irq_pkg;
    typedef enum logic [1:0] {
        ACK_LEVEL     = 2'd0,
        ACK_EDGE_W1C  = 2'd1,
        ACK_LATCH_W0C = 2'd2
    } ack_mode_e;

    localparam logic SEL_MASK   = 1'b0;
    localparam logic SEL_STATUS = 1'b1;
endpackage

// File: rtl/irq_mask_reg.sv
// Enable mask register.
// Loads the whole word on a write and clears to zero on reset.
// Assumes wr_en is already qualified by the register select.
module irq_mask_reg #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] mask_q
);
    // Holds the enables; reset leaves every line disabled.
    always_ff @(posedge clk) begin : p_mask
        if (!rst_n)      mask_q <= '0;
        else if (wr_en)  mask_q <= wdata;
    end

    AST_MASK_RESET: assert property (@(posedge clk) !rst_n |=> mask_q == '0); // R2
    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mask_q == $past(wdata)); // R1
endmodule

// File: rtl/irq_status_bank.sv
// Pending status word with a build-time acknowledge mode.
//   ACK_LEVEL     : status samples irq_in every cycle; writes are ignored.
//   ACK_EDGE_W1C  : a rising input sets a bit; writing 1 clears it; set wins.
//   ACK_LATCH_W0C : a high input sets a bit; writing 0 clears it; set wins.
// Assumes irq_in is synchronous to clk and wr_en is already qualified.
module irq_status_bank
    import cpu_irq_pkg::*;
#(
    parameter int        N    = 32,
    parameter ack_mode_e MODE = ACK_LATCH_W0C
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] irq_in,
    input  logic         wr_en,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] status_q
);
    logic [N-1:0] status_nxt;

    // Holds the pending bits.
    always_ff @(posedge clk) begin : p_status
        if (!rst_n) status_q <= '0;
        else        status_q <= status_nxt;
    end

    if (MODE == ACK_EDGE_W1C) begin : g_edge
        logic [N-1:0] irq_d;
        logic [N-1:0] rise;
        logic [N-1:0] clr;

        // Keeps last cycle's inputs for edge detection.
        always_ff @(posedge clk) begin : p_delay
            if (!rst_n) irq_d <= '0;
            else        irq_d <= irq_in;
        end

        // Next status: clear written ones, then apply new edges.
        always_comb begin : p_next
            rise       = irq_in & ~irq_d;
            clr        = wr_en ? wdata : '0;
            status_nxt = (status_q & ~clr) | rise;
        end

        AST_EDGE_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (|rise) |=> (status_q & $past(rise)) == $past(rise)); // R4
        AST_EDGE_W1C: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && ((wdata & rise) == '0)) |=> (status_q & $past(wdata)) == '0); // R3
        AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en |=> (status_q & $past(status_q)) == $past(status_q)); // R3
    end else if (MODE == ACK_LATCH_W0C) begin : g_latch
        logic [N-1:0] keep;

        // Next status: written zeros clear, high inputs set.
        always_comb begin : p_next
            keep       = wr_en ? wdata : '1;
            status_nxt = (status_q & keep) | irq_in;
        end

        AST_LATCH_SET: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> (status_q & $past(irq_in)) == $past(irq_in)); // R5
        AST_LATCH_W0C: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |=> (status_q & ~$past(wdata) & ~$past(irq_in)) == '0); // R6
        AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en |=> (status_q & $past(status_q)) == $past(status_q)); // R5
    end else begin : g_level
        logic unused_wr;
        assign unused_wr = ^{wr_en, wdata};

        // Next status: plain sample of the inputs.
        always_comb begin : p_next
            status_nxt = irq_in;
        end

        AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> status_q == $past(irq_in)); // R7
    end
endmodule

// File: rtl/irq_lowest_pick.sv
// Lowest-set-bit finder over the armed (status AND mask) vector.
// Purely combinational; idx is 0 when nothing is set.
module irq_lowest_pick #(
    parameter int N  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          valid,
    output logic [IW-1:0] idx
);
    // Scans from the top so the lowest set bit is the last to assign.
    always_comb begin : p_scan
        idx   = '0;
        valid = |vec;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/cpu_irq_ctrl.sv
// Top of the interrupt controller.
// Decodes the register port, combines status with mask, registers the
// request to the core and reports the lowest enabled pending line.
// Assumes synchronous inputs and a reset asserted from time zero.
module cpu_irq_ctrl
    import cpu_irq_pkg::*;
#(
    parameter int        N    = 32,
    parameter ack_mode_e MODE = ACK_LATCH_W0C,
    localparam int       IW   = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  irq_in,
    input  logic          reg_wr,
    input  logic          reg_sel,
    input  logic [N-1:0]  reg_wdata,
    output logic [N-1:0]  reg_rdata,
    output logic          cpu_irq,
    output logic          pend_valid,
    output logic [IW-1:0] pend_idx
);
    localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

    logic [N-1:0] mask_q;
    logic [N-1:0] status_q;
    logic [N-1:0] armed;
    logic         mask_wr;
    logic         stat_wr;

    assign mask_wr   = reg_wr && (reg_sel == SEL_MASK);
    assign stat_wr   = reg_wr && (reg_sel == SEL_STATUS);
    assign reg_rdata = (reg_sel == SEL_STATUS) ? status_q : mask_q;
    assign armed     = status_q & mask_q;

    irq_mask_reg #(.N(N)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (mask_wr),
        .wdata  (reg_wdata),
        .mask_q (mask_q)
    );

    irq_status_bank #(.N(N), .MODE(MODE)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_in   (irq_in),
        .wr_en    (stat_wr),
        .wdata    (reg_wdata),
        .status_q (status_q)
    );

    irq_lowest_pick #(.N(N), .IW(IW)) u_pick (
        .vec   (armed),
        .valid (pend_valid),
        .idx   (pend_idx)
    );

    // Registers the request to the core.
    always_ff @(posedge clk) begin : p_irq
        if (!rst_n) cpu_irq <= 1'b0;
        else        cpu_irq <= |armed;
    end

    AST_IRQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> cpu_irq == $past(|(status_q & mask_q))); // R8
    AST_PICK_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> armed[pend_idx]); // R9
    AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> (armed & ((ONE << pend_idx) - ONE)) == '0); // R9
    AST_PICK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_valid |-> (armed == '0) && (pend_idx == '0)); // R9
    AST_MASK_INDEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_wr && MODE != ACK_LEVEL) |=> (status_q & $past(status_q)) == $past(status_q)); // R10
endmodule

// File: tb/cpu_irq_ctrl_test.sv
`timescale 1ns/1ps
module cpu_irq_ctrl_test;
    import cpu_irq_pkg::*;

    typedef struct packed {
        logic [31:0] irq;
        logic        wr;
        logic [31:0] wdata;
        logic [31:0] e_latch;
        logic [31:0] e_edge;
        logic [31:0] e_level;
        logic        vld;
        logic [4:0]  idx;
    } vec_t;

    // Status-port walk with mask all ones; expected idx/valid for latched mode.
    localparam vec_t VECS [11] = '{
        '{32'h0000_0005, 1'b0, 32'h0000_0000, 32'h0000_0005, 32'h0000_0005, 32'h0000_0005, 1'b1, 5'd0},
        '{32'h0000_0000, 1'b0, 32'h0000_0000, 32'h0000_0005, 32'h0000_0005, 32'h0000_0000, 1'b1, 5'd0},
        '{32'h0000_0000, 1'b1, 32'hFFFF_FFFE, 32'h0000_0004, 32'h0000_0001, 32'h0000_0000, 1'b1, 5'd2},
        '{32'h0000_0000, 1'b1, 32'h0000_0001, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 1'b0, 5'd0},
        '{32'h0000_0100, 1'b0, 32'h0000_0000, 32'h0000_0100, 32'h0000_0100, 32'h0000_0100, 1'b1, 5'd8},
        '{32'h0000_0100, 1'b1, 32'h0000_0000, 32'h0000_0100, 32'h0000_0100, 32'h0000_0100, 1'b1, 5'd8},
        '{32'h0000_0100, 1'b1, 32'hFFFF_FFFF, 32'h0000_0100, 32'h0000_0000, 32'h0000_0100, 1'b1, 5'd8},
        '{32'h8000_0001, 1'b1, 32'h0000_0000, 32'h8000_0001, 32'h8000_0001, 32'h8000_0001, 1'b1, 5'd0},
        '{32'h8000_0001, 1'b1, 32'h8000_0001, 32'h8000_0001, 32'h0000_0000, 32'h8000_0001, 1'b1, 5'd0},
        '{32'h0000_0000, 1'b1, 32'h7FFF_FFFF, 32'h0000_0001, 32'h0000_0000, 32'h0000_0000, 1'b1, 5'd0},
        '{32'h0000_0002, 1'b1, 32'hFFFF_FFFF, 32'h0000_0003, 32'h0000_0002, 32'h0000_0002, 1'b1, 5'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;

    logic [31:0] rd_latch, rd_edge, rd_level;
    logic        irq_latch, irq_edge, irq_level;
    logic        vld_latch, vld_edge, vld_level;
    logic [4:0]  idx_latch, idx_edge, idx_level;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    cpu_irq_ctrl #(.MODE(ACK_LATCH_W0C)) uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(rd_latch), .cpu_irq(irq_latch),
        .pend_valid(vld_latch), .pend_idx(idx_latch));

    cpu_irq_ctrl #(.MODE(ACK_EDGE_W1C)) uut_edge (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(rd_edge), .cpu_irq(irq_edge),
        .pend_valid(vld_edge), .pend_idx(idx_edge));

    cpu_irq_ctrl #(.MODE(ACK_LEVEL)) uut_level (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(rd_level), .cpu_irq(irq_level),
        .pend_valid(vld_level), .pend_idx(idx_level));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Stops driving writes and selects a register for a combinational read.
    task automatic look(input logic sel);
        reg_wr  = 1'b0;
        reg_sel = sel;
        #1;
    endtask

    task automatic wr_reg(input logic sel, input logic [31:0] data);
        reg_wr    = 1'b1;
        reg_sel   = sel;
        reg_wdata = data;
        tick();
        look(sel);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        irq_in = '0;
        reg_wr = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        #(200000 * 8);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        do_reset();
        // R2: reset state
        look(SEL_MASK);
        check("R2 mask", rd_latch, 32'h0);
        look(SEL_STATUS);
        check("R2 status", rd_edge, 32'h0);
        check("R2 irq", {31'b0, irq_latch}, 32'h0);
        check("R2 valid", {31'b0, vld_level}, 32'h0);

        // R1: enable every line, read it back
        wr_reg(SEL_MASK, 32'hFFFF_FFFF);
        check("R1 mask readback", rd_latch, 32'hFFFF_FFFF);

        foreach (VECS[i]) begin
            irq_in    = VECS[i].irq;
            reg_wr    = VECS[i].wr;
            reg_sel   = SEL_STATUS;
            reg_wdata = VECS[i].wdata;
            tick();
            look(SEL_STATUS);
            check("R5 R6 latched status", rd_latch, VECS[i].e_latch);
            check("R3 R4 edge status", rd_edge, VECS[i].e_edge);
            check("R7 level status", rd_level, VECS[i].e_level);
            check("R9 valid", {31'b0, vld_latch}, {31'b0, VECS[i].vld});
            check("R9 idx", {27'b0, idx_latch}, {27'b0, VECS[i].idx});
        end

        // R2: reset clears a loaded mask
        do_reset();
        look(SEL_MASK);
        check("R2 mask after reset", rd_latch, 32'h0);

        // R10: masked line still pending; R8 no request
        irq_in = 32'h0000_0008;
        tick();
        look(SEL_STATUS);
        check("R10 masked pending visible", rd_latch, 32'h0000_0008);
        check("R9 masked not picked", {31'b0, vld_latch}, 32'h0);
        tick();
        check("R8 masked no irq", {31'b0, irq_latch}, 32'h0);

        // R8: one-cycle latency after enabling
        wr_reg(SEL_MASK, 32'h0000_0008);
        check("R8 irq low right after enable", {31'b0, irq_latch}, 32'h0);
        check("R9 idx 3", {27'b0, idx_latch}, 32'd3);
        tick();
        check("R8 irq high next cycle", {31'b0, irq_latch}, 32'h1);
        check("R8 level irq high", {31'b0, irq_level}, 32'h1);

        // R7: masking alone quiets a level line
        wr_reg(SEL_MASK, 32'h0);
        tick();
        check("R7 level quiet by mask", {31'b0, irq_level}, 32'h0);
        look(SEL_STATUS);
        check("R7 level status still high", rd_level, 32'h0000_0008);

        // R9: priority among several lines
        irq_in = 32'h8002_0028;
        wr_reg(SEL_MASK, 32'hFFFF_FFFF);
        look(SEL_STATUS);
        check("R9 lowest of many", {27'b0, idx_latch}, 32'd3);
        irq_in = 32'h0;
        wr_reg(SEL_STATUS, 32'hFFFF_FFF7);
        check("R6 clear one bit only", rd_latch, 32'h8002_0020);
        check("R9 next lowest", {27'b0, idx_latch}, 32'd5);
        wr_reg(SEL_MASK, 32'hFFFF_FFDF);
        check("R1 mask rmw readback", rd_latch, 32'hFFFF_FFDF);
        check("R9 skip masked", {27'b0, idx_latch}, 32'd17);
        wr_reg(SEL_MASK, 32'h0);
        check("R9 none valid", {31'b0, vld_latch}, 32'h0);
        check("R9 none idx", {27'b0, idx_latch}, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule